// File: doc/BRIEF.md
# Line-Independent Difference Encoder

This block turns a stream of 8-bit pixels into a packed byte stream without loss. Pixels arrive in lines, and the encoder treats every line on its own. The opening pixel of a line goes out as a plain 8-bit literal. Each pixel after it is predicted from its left neighbour. The wrapped difference is coded with one fixed variable-length prefix code, and no codeword is longer than 16 bits. Codewords are packed most-significant bit first into bytes. When a line ends, the packer fills the last partial byte with zeros, so the next line begins on a byte boundary.

A pass-through mode sends every pixel of a line as a literal, which leaves the data uncompressed. Both sides of the block use valid/ready handshakes. The pixel side also carries flags that mark the first and last pixel of a line. The encoder holds its pixel input off whenever its bit buffer has no room left for a codeword of the longest length.

Top module: `linediff_huff_enc`

## Requirements
- R1: The pixel flagged as first in a line is emitted as its 8 bits unchanged, whatever pixel came before it. No prediction crosses a line boundary.
- R2: Every other pixel is coded from d = (current − left neighbour) mod 256, read as a signed value from −128 to +127.
- R3: The code for d uses category k, the bit length of |d| (k=0 when d=0, k=8 only when d=−128). The prefix is k one-bits followed by a zero-bit when k<8, or eight one-bits when k=8. After the prefix come k extra bits: d itself when d≥0, or d+2^k−1 when d<0. Code length is therefore at most 16 bits.
- R4: Codewords go into output bytes most-significant bit first. Bit 7 of each byte is the earliest bit in the stream.
- R5: After the last pixel of a line, any partial byte is completed with zero bits and emitted. No other padding bytes appear.
- R6: raw_mode_i is sampled only with a line's first pixel. When it is 1, every pixel of that line is an 8-bit literal. Its value on later pixels of the line has no effect.
- R7: While byte_valid_o is high and byte_ready_i is low, byte_valid_o stays high and byte_data_o stays unchanged.
- R8: pix_ready_o is low whenever the bit buffer could not take a 16-bit codeword. No pixel or bit is ever lost under output backpressure.
- R9: During reset, byte_valid_o is low and pix_ready_o is high.
- R10: After a pixel flagged last is accepted, pix_ready_o stays low until the padded tail of that line has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Pixel offered |
| pix_ready_o | output | 1 | Encoder can accept the pixel |
| pix_data_i | input | 8 | Pixel value |
| pix_first_i | input | 1 | Pixel starts a line |
| pix_last_i | input | 1 | Pixel ends a line |
| raw_mode_i | input | 1 | Pass-through request, sampled with the first pixel |
| byte_valid_o | output | 1 | Output byte available |
| byte_ready_i | input | 1 | Consumer takes the byte |
| byte_data_o | output | 8 | Packed output byte |

## Verification
The assertions check on every cycle that:
- the output byte is held steady under backpressure;
- the buffer fill never exceeds capacity;
- an empty buffer never claims a byte;
- input is blocked right after a line end;
- the reset values are correct.

Only the bench scenarios can show that the byte stream is correct. This includes the value of every difference code, literal line starts, line-end zero padding, raw lines in which the mode input toggles mid-line, and stall under output backpressure. The bench shows this by sweeping all 256 differences and many short lines against an arithmetic model.

// File: rtl/lde_pkg.sv
package lde_pkg;
    localparam int PIX_W  = 8;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 2 * PIX_W;
    localparam int BUF_W  = CODE_W + BYTE_W;
    localparam int LEN_W  = $clog2(CODE_W + 1);
    localparam int CNT_W  = $clog2(BUF_W + 1);

    typedef struct packed {
        logic [PIX_W-1:0] prev;
        logic             raw;
    } pred_state_t;

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic             flush;
    } pack_state_t;
endpackage

// File: rtl/lde_vlc.sv
module lde_vlc
    import lde_pkg::*;
(
    input  logic [PIX_W-1:0]  diff_i,
    output logic [CODE_W-1:0] code_o,
    output logic [LEN_W-1:0]  len_o
);
    logic [PIX_W:0]    mag;
    logic [LEN_W-1:0]  cat;
    logic [LEN_W-1:0]  plen;
    logic [PIX_W-1:0]  ext;
    logic [PIX_W-1:0]  ext_m;
    logic [CODE_W-1:0] pre;
    logic [CODE_W-1:0] body;

    always_comb begin
        // magnitude of the signed difference
        mag = diff_i[PIX_W-1] ? ((PIX_W+1)'(1) << PIX_W) - {1'b0, diff_i}
                              : {1'b0, diff_i};
        // category = bit length of the magnitude
        cat = '0;
        for (int i = 0; i <= PIX_W; i++) begin
            if (mag[i]) cat = LEN_W'(i + 1);
        end
        ext   = diff_i[PIX_W-1] ? diff_i - 1'b1 : diff_i;
        ext_m = ext & ~({PIX_W{1'b1}} << cat);
        if (cat == LEN_W'(PIX_W)) begin
            pre  = CODE_W'({PIX_W{1'b1}});
            plen = LEN_W'(PIX_W);
        end else begin
            pre  = ((CODE_W'(1) << cat) - CODE_W'(1)) << 1;
            plen = cat + LEN_W'(1);
        end
        len_o  = plen + cat;
        body   = (pre << cat) | CODE_W'(ext_m);
        code_o = body << (LEN_W'(CODE_W) - len_o);
    end
endmodule

// File: rtl/lde_predict.sv
module lde_predict
    import lde_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              first_i,
    input  logic              raw_i,
    input  logic              take_i,
    output logic [CODE_W-1:0] code_o,
    output logic [LEN_W-1:0]  len_o
);
    pred_state_t       st_d, st_q;
    logic [PIX_W-1:0]  diff;
    logic [CODE_W-1:0] vcode;
    logic [LEN_W-1:0]  vlen;
    logic              literal;

    assign diff = pix_i - st_q.prev;

    lde_vlc u_vlc (
        .diff_i (diff),
        .code_o (vcode),
        .len_o  (vlen)
    );

    always_comb begin
        literal = first_i || st_q.raw;
        code_o  = literal ? {pix_i, {(CODE_W-PIX_W){1'b0}}} : vcode;
        len_o   = literal ? LEN_W'(PIX_W) : vlen;
        st_d    = st_q;
        if (take_i) begin
            st_d.prev = pix_i;
            if (first_i) st_d.raw = raw_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lde_packer.sv
module lde_packer
    import lde_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              last_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              room_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [CNT_W-1:0]  fill_o
);
    pack_state_t st_d, st_q;
    logic        pop;

    assign valid_o = (st_q.cnt >= CNT_W'(BYTE_W)) || (st_q.flush && st_q.cnt != '0);
    assign room_o  = (st_q.cnt <= CNT_W'(BUF_W - CODE_W)) && !st_q.flush;
    assign byte_o  = st_q.bits[BUF_W-1 -: BYTE_W];
    assign fill_o  = st_q.cnt;
    assign pop     = valid_o && ready_i;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.bits = st_q.bits << BYTE_W;
            st_d.cnt  = (st_q.cnt > CNT_W'(BYTE_W)) ? st_q.cnt - CNT_W'(BYTE_W) : '0;
            if (st_q.flush && st_q.cnt <= CNT_W'(BYTE_W)) st_d.flush = 1'b0;
        end
        if (push_i) begin
            st_d.bits = st_d.bits | ({code_i, {(BUF_W-CODE_W){1'b0}}} >> st_d.cnt);
            st_d.cnt  = st_d.cnt + CNT_W'(len_i);
            if (last_i) st_d.flush = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/linediff_huff_enc.sv
module linediff_huff_enc
    import lde_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    output logic              pix_ready_o,
    input  logic [PIX_W-1:0]  pix_data_i,
    input  logic              pix_first_i,
    input  logic              pix_last_i,
    input  logic              raw_mode_i,
    output logic              byte_valid_o,
    input  logic              byte_ready_i,
    output logic [BYTE_W-1:0] byte_data_o
);
    logic              take;
    logic              room;
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
    logic [CNT_W-1:0]  fill_cnt;

    assign pix_ready_o = room;
    assign take        = pix_valid_i && room;

    lde_predict u_predict (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_i   (pix_data_i),
        .first_i (pix_first_i),
        .raw_i   (raw_mode_i),
        .take_i  (take),
        .code_o  (code),
        .len_o   (len)
    );

    lde_packer u_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (take),
        .last_i  (pix_last_i),
        .code_i  (code),
        .len_i   (len),
        .room_o  (room),
        .byte_o  (byte_data_o),
        .valid_o (byte_valid_o),
        .ready_i (byte_ready_i),
        .fill_o  (fill_cnt)
    );
endmodule

// File: rtl/linediff_huff_enc_chk.sv
module linediff_huff_enc_chk
    import lde_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              pix_last,
    input logic              byte_valid,
    input logic              byte_ready,
    input logic [BYTE_W-1:0] byte_data,
    input logic [CNT_W-1:0]  fill
);
    // R7: output held under backpressure
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    // R8: buffer never exceeds capacity
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (fill <= CNT_W'(BUF_W)));

    // R5: an empty buffer offers no byte (no spurious padding)
    p_empty_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !byte_valid);

    // R10: line end blocks the next pixel
    p_last_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && pix_last) |=> !pix_ready);

    // R9: reset values
    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (!byte_valid && pix_ready));
endmodule

bind linediff_huff_enc linediff_huff_enc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid_i),
    .pix_ready  (pix_ready_o),
    .pix_last   (pix_last_i),
    .byte_valid (byte_valid_o),
    .byte_ready (byte_ready_i),
    .byte_data  (byte_data_o),
    .fill       (fill_cnt)
);

// File: tb/linediff_huff_enc_tb_top.sv
module linediff_huff_enc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic       pix_ready;
    logic [7:0] pix_data = '0;
    logic       pix_first = 1'b0;
    logic       pix_last = 1'b0;
    logic       raw_mode = 1'b0;
    logic       byte_valid;
    logic       byte_ready = 1'b0;
    logic [7:0] byte_data;

    int checks = 0;
    int errors = 0;
    int exp_b [0:16383];
    int ne = 0;
    int nr = 0;
    int acc = 0;
    int nb = 0;
    int model_prev = 0;
    bit model_raw = 1'b0;
    int ready_mode = 0;
    bit done = 1'b0;
    bit held_v = 1'b0;
    logic [7:0] held_d = '0;
    string cur_tag = "R9";
    int lb [0:299];

    always #5 clk = ~clk;

    linediff_huff_enc dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid_i  (pix_valid),
        .pix_ready_o  (pix_ready),
        .pix_data_i   (pix_data),
        .pix_first_i  (pix_first),
        .pix_last_i   (pix_last),
        .raw_mode_i   (raw_mode),
        .byte_valid_o (byte_valid),
        .byte_ready_i (byte_ready),
        .byte_data_o  (byte_data)
    );

    task automatic check(bit ok, string tag, int got, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    // bit-level model of the packed stream
    task automatic put_bit(int b);
        acc = ((acc << 1) | b) & 255;
        nb++;
        if (nb == 8) begin
            exp_b[ne] = acc; ne++; acc = 0; nb = 0;
        end
    endtask

    task automatic put_bits(int val, int n);
        for (int i = n - 1; i >= 0; i--) put_bit((val >> i) & 1);
    endtask

    task automatic model_pixel(int p, bit first, bit last, bit raw);
        if (first) model_raw = raw;
        if (first || model_raw) put_bits(p, 8);
        else begin
            int d, mag, k, e;
            d = p - model_prev;
            if (d > 127) d -= 256;
            if (d < -128) d += 256;
            mag = (d < 0) ? -d : d;
            k = 0;
            while ((1 << k) <= mag) k++;
            if (k < 8) put_bits(((1 << k) - 1) << 1, k + 1);
            else put_bits(255, 8);
            if (k > 0) begin
                e = (d >= 0) ? d : d + (1 << k) - 1;
                put_bits(e, k);
            end
        end
        model_prev = p;
        if (last && nb > 0) begin
            exp_b[ne] = (acc << (8 - nb)) & 255; ne++; acc = 0; nb = 0;
        end
    endtask

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic send_pix(int p, bit first, bit last, bit raw);
        pix_data = 8'(p); pix_first = first; pix_last = last; raw_mode = raw;
        pix_valid = 1'b1;
        while (!pix_ready) @(negedge clk);
        model_pixel(p, first, last, raw);
        @(negedge clk);
        pix_valid = 1'b0;
        if (last) check(!pix_ready, "R10 ready after last", pix_ready, 0);
    endtask

    task automatic send_line(int n, bit rawm, bit noise);
        for (int i = 0; i < n; i++) begin
            bit r;
            r = (i == 0) ? rawm : (noise ? 1'($urandom % 2) : rawm);
            send_pix(lb[i], i == 0, i == n - 1, r);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && nr != ne; i++) @(negedge clk);
        check(nr == ne, {cur_tag, " drain"}, nr, ne);
    endtask

    // output side: drive ready, then record the handshake of the coming edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (held_v) check(byte_valid && byte_data == held_d, "R7 hold", byte_data, held_d);
            case (ready_mode)
                0: byte_ready = 1'b1;
                1: byte_ready = 1'($urandom % 2);
                default: byte_ready = 1'b0;
            endcase
            held_v = byte_valid && !byte_ready;
            held_d = byte_data;
            if (byte_valid && byte_ready) begin
                if (nr >= ne) check(1'b0, {cur_tag, " extra byte"}, byte_data, -1);
                else check(byte_data == 8'(exp_b[nr]), cur_tag, byte_data, exp_b[nr]);
                nr++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!byte_valid, "R9 byte_valid in reset", byte_valid, 0);
        check(pix_ready, "R9 pix_ready in reset", pix_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep every difference: p[i] = p[i-1] + d, d = -128..127
        lb[0] = 0;
        for (int d = -128; d <= 127; d++) lb[d + 129] = (lb[d + 128] + d) & 255;
        cur_tag = "R2 R3 R4 sweep";
        ready_mode = 0;
        send_line(257, 1'b0, 1'b0);
        drain();
        cur_tag = "R7 R8 sweep backpressure";
        ready_mode = 1;
        send_line(257, 1'b0, 1'b0);
        drain();

        // raw lines with a toggling mode input after the first pixel
        cur_tag = "R6 raw line";
        for (int i = 0; i < 20; i++) lb[i] = (i * 37 + 11) & 255;
        send_line(20, 1'b1, 1'b1);
        drain();
        cur_tag = "R6 coded line, mode noise ignored";
        send_line(20, 1'b0, 1'b1);
        drain();

        // short lines: literal starts and zero padding
        cur_tag = "R1 R5 short lines";
        for (int ln = 0; ln < 60; ln++) begin
            int n;
            n = 1 + (ln % 9);
            for (int i = 0; i < n; i++)
                lb[i] = (ln % 2 == 0) ? ($urandom % 256) : ((100 + ln + i * (ln % 5)) & 255);
            send_line(n, 1'($urandom % 4 == 0), 1'b1);
        end
        drain();

        // stall: literal 8 bits + a 16-bit code fills the buffer
        cur_tag = "R8 stall";
        ready_mode = 2;
        @(negedge clk);
        send_pix(0, 1'b1, 1'b0, 1'b0);
        send_pix(128, 1'b0, 1'b0, 1'b0);
        check(!pix_ready, "R8 ready with full buffer", pix_ready, 0);
        check(byte_valid, "R8 byte pending", byte_valid, 1);
        ready_mode = 0;
        send_pix(5, 1'b0, 1'b1, 1'b0);
        drain();

        repeat (20) @(negedge clk);
        check(!byte_valid, "R5 no trailing byte", byte_valid, 0);
        check(nr == ne, "R5 total bytes", nr, ne);
        check(pix_ready, "R10 ready after tail", pix_ready, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule